// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block loads a bitstream into a target FPGA that is configured in passive serial mode over SPI. A single start pulse runs the whole sequence. The block lowers chip select, pulses the target's active-low configuration reset, and waits a setup interval. It then shifts out every bitstream byte that arrives on a ready/valid byte port, with the end of the image marked by a last flag. After the last byte it clocks a fixed number of all-zero bytes, releases chip select, and optionally polls the target's done input against a timeout. It then waits a user-mode settling interval and ends with a one-cycle success or error pulse.

The SPI link runs in mode 3 only: the serial clock idles high, the data line changes on the falling edge, and the target samples on the rising edge. The serial clock is derived from the system clock by a half-period divider parameter. The reset width, setup interval, done timeout and user-mode wait are all cycle-count parameters, so the host picks the margins for its own clock frequency. A separate status output tells whether the target's done line is currently high.

Top module: `fpga_cfg_seq`

## Requirements
- R1: The serial clock sits high whenever chip select is high. The data line changes only together with a falling serial clock edge. Every rising edge carries a stable bit.
- R2: Chip select goes low at least one cycle before the reset output falls. It stays low through the reset pulse, the setup interval, the whole bitstream and all trailing bytes, and it rises exactly once per sequence.
- R3: The reset output is low for exactly RST_CYC system clock cycles per sequence, and it falls exactly once.
- R4: The first falling serial clock edge comes at least SETUP_CYC cycles after the reset output rises.
- R5: Each byte is sent MSB first. `s_ready` is high only while the block waits for data and the shifter is empty. The byte accepted with `s_last` = 1 is the last bitstream byte.
- R6: After the last bitstream byte, TRAIL_BYTES bytes of value 0x00 are sent, so exactly 8 × (N + TRAIL_BYTES) rising edges occur while chip select is low, for N bitstream bytes.
- R7: Chip select rises only after the final rising serial clock edge of the trailing bytes, with the serial clock high.
- R8: With polling enabled (`done_poll_en` = 1 at start), if the synchronized done input stays low, `cfg_err` pulses exactly TIMEOUT_CYC cycles after chip select rises.
- R9: With polling enabled and done going high, `cfg_ok` pulses no sooner than USER_CYC cycles after done rises.
- R10: With polling disabled, the done input is ignored and `cfg_ok` pulses exactly USER_CYC cycles after chip select rises.
- R11: `tgt_operating` is 1 within four cycles of the done input being high, and 0 within four cycles of it being low.
- R12: `busy` is high from the cycle after start until the result pulse. Exactly one of `cfg_ok` or `cfg_err` is high, for one cycle. A start pulse while busy has no effect. After reset, chip select, reset output and serial clock are high, while `busy`, `s_ready`, `cfg_ok` and `cfg_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a load |
| done_poll_en | input | 1 | 1: poll the done input after the data; sampled at start |
| s_data | input | 8 | Bitstream byte |
| s_valid | input | 1 | Byte on s_data is valid |
| s_last | input | 1 | Byte on s_data is the final bitstream byte |
| s_ready | output | 1 | Block accepts the byte this cycle |
| cfg_rst_n | output | 1 | Active-low configuration reset to target |
| cfg_done | input | 1 | Configuration-done input from target (asynchronous) |
| spi_cs_n | output | 1 | Active-low SPI chip select |
| spi_sck | output | 1 | SPI serial clock, idles high |
| spi_mosi | output | 1 | SPI data to target |
| busy | output | 1 | Sequence in progress |
| cfg_ok | output | 1 | One-cycle pulse: load finished and user-mode wait elapsed |
| cfg_err | output | 1 | One-cycle pulse: done did not rise before the timeout |
| tgt_operating | output | 1 | 1 when the target reports done (operating), 0 when unknown |

## Verification
The bench builds the block with a half-period divider of 2, a 5-cycle reset, a 20-cycle setup, a 15-cycle user wait, a 200-cycle done timeout and the default 13 trailing bytes. Short timed phases let every sequence finish in about a thousand cycles. They also let the bench compare the reset width, timeout and user wait against exact cycle counts, and not only against lower bounds. With the divider at 2, the rising edges can be counted one by one and each shifted byte rebuilt, including all thirteen trailing zeros, across one-byte and multi-byte images with stalled input streams.

// File: rtl/fpga_cfg_seq_pkg.sv
package fpga_cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEAD   = 3'd1,
    ST_RSTLOW = 3'd2,
    ST_SETUP  = 3'd3,
    ST_DATA   = 3'd4,
    ST_TRAIL  = 3'd5,
    ST_POLL   = 3'd6,
    ST_USER   = 3'd7
  } seq_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/fpga_cfg_seq_timer.sv
module fpga_cfg_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/fpga_cfg_seq_sync.sv
module fpga_cfg_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fpga_cfg_seq_shift.sv
module fpga_cfg_seq_shift
  import fpga_cfg_seq_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  output logic              active,
  output logic              sck,
  output logic              mosi
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

  logic [BYTE_W-1:0] sh;
  logic [DIV_W-1:0]  div;
  logic [BIT_W-1:0]  bits_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      sck       <= 1'b1;
      mosi      <= 1'b0;
      sh        <= '0;
      div       <= '0;
      bits_left <= '0;
    end else if (!active) begin
      if (load) begin
        sh        <= din;
        mosi      <= din[BYTE_W-1];
        sck       <= 1'b0;
        div       <= '0;
        bits_left <= BIT_W'(BYTE_W);
        active    <= 1'b1;
      end
    end else if (div == DIV_END) begin
      div <= '0;
      if (!sck) begin
        sck       <= 1'b1;
        bits_left <= bits_left - 1'b1;
      end else if (bits_left == '0) begin
        active <= 1'b0;
      end else begin
        sck  <= 1'b0;
        sh   <= {sh[BYTE_W-2:0], 1'b0};
        mosi <= sh[BYTE_W-2];
      end
    end else begin
      div <= div + 1'b1;
    end
  end

endmodule

// File: rtl/fpga_cfg_seq.sv
module fpga_cfg_seq
  import fpga_cfg_seq_pkg::*;
#(
  parameter int HALF_DIV    = 2,
  parameter int RST_CYC     = 75,
  parameter int SETUP_CYC   = 1750,
  parameter int USER_CYC    = 1500,
  parameter int TIMEOUT_CYC = 50000,
  parameter int TRAIL_BYTES = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              done_poll_en,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              cfg_rst_n,
  input  logic              cfg_done,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              busy,
  output logic              cfg_ok,
  output logic              cfg_err,
  output logic              tgt_operating
);

  localparam int MAX_A = (RST_CYC > SETUP_CYC) ? RST_CYC : SETUP_CYC;
  localparam int MAX_B = (MAX_A > USER_CYC) ? MAX_A : USER_CYC;
  localparam int MAX_C = (MAX_B > TIMEOUT_CYC) ? MAX_B : TIMEOUT_CYC;
  localparam int TW    = $clog2(MAX_C + 1);
  localparam int TBW   = $clog2(TRAIL_BYTES + 1);

  seq_state_t        state, nxt;
  logic              last_seen;
  logic              poll_q;
  logic [TBW-1:0]    trail_left;
  logic              tmr_load;
  logic [TW-1:0]     tmr_val;
  logic              tmr_zero;
  logic              sh_load;
  logic [BYTE_W-1:0] sh_din;
  logic              sh_busy;
  logic              done_s;
  logic              fin_ok;
  logic              fin_err;
  logic              take;

  fpga_cfg_seq_timer #(.W(TW)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  fpga_cfg_seq_shift #(.HALF_DIV(HALF_DIV)) shift_i (
    .clk    (clk),
    .rst    (rst),
    .load   (sh_load),
    .din    (sh_din),
    .active (sh_busy),
    .sck    (spi_sck),
    .mosi   (spi_mosi)
  );

  fpga_cfg_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (cfg_done),
    .q   (done_s)
  );

  assign s_ready = (state == ST_DATA) && !sh_busy && !last_seen;
  assign take    = s_ready && s_valid;

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_din   = '0;
    fin_ok   = 1'b0;
    fin_err  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) nxt = ST_LEAD;
      end
      ST_LEAD: begin
        nxt      = ST_RSTLOW;
        tmr_load = 1'b1;
        tmr_val  = TW'(RST_CYC - 1);
      end
      ST_RSTLOW: begin
        if (tmr_zero) begin
          nxt      = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = TW'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_zero) nxt = ST_DATA;
      end
      ST_DATA: begin
        if (take) begin
          sh_load = 1'b1;
          sh_din  = s_data;
        end else if (last_seen && !sh_busy) begin
          nxt = ST_TRAIL;
        end
      end
      ST_TRAIL: begin
        if (!sh_busy) begin
          if (trail_left != '0) begin
            sh_load = 1'b1;
          end else if (poll_q) begin
            nxt      = ST_POLL;
            tmr_load = 1'b1;
            tmr_val  = TW'(TIMEOUT_CYC - 1);
          end else begin
            nxt      = ST_USER;
            tmr_load = 1'b1;
            tmr_val  = TW'(USER_CYC - 1);
          end
        end
      end
      ST_POLL: begin
        if (done_s) begin
          nxt      = ST_USER;
          tmr_load = 1'b1;
          tmr_val  = TW'(USER_CYC - 1);
        end else if (tmr_zero) begin
          nxt     = ST_IDLE;
          fin_err = 1'b1;
        end
      end
      ST_USER: begin
        if (tmr_zero) begin
          nxt    = ST_IDLE;
          fin_ok = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      last_seen     <= 1'b0;
      poll_q        <= 1'b0;
      trail_left    <= '0;
      spi_cs_n      <= 1'b1;
      cfg_rst_n     <= 1'b1;
      busy          <= 1'b0;
      cfg_ok        <= 1'b0;
      cfg_err       <= 1'b0;
      tgt_operating <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        last_seen <= 1'b0;
        poll_q    <= done_poll_en;
      end else if (take && s_last) begin
        last_seen <= 1'b1;
      end
      if (state == ST_DATA && nxt == ST_TRAIL) begin
        trail_left <= TBW'(TRAIL_BYTES);
      end else if (state == ST_TRAIL && sh_load) begin
        trail_left <= trail_left - 1'b1;
      end
      spi_cs_n      <= !(nxt inside {ST_LEAD, ST_RSTLOW, ST_SETUP, ST_DATA, ST_TRAIL});
      cfg_rst_n     <= (nxt != ST_RSTLOW);
      busy          <= (nxt != ST_IDLE);
      cfg_ok        <= fin_ok;
      cfg_err       <= fin_err;
      tgt_operating <= done_s;
    end
  end

endmodule

// File: rtl/fpga_cfg_seq_chk.sv
module fpga_cfg_seq_chk (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi,
  input logic cfg_rst_n,
  input logic s_ready,
  input logic busy,
  input logic cfg_ok,
  input logic cfg_err
);

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> spi_sck);  // R1

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$fell(spi_sck) |-> $stable(spi_mosi));  // R1

  AST_FALL_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    $fell(spi_sck) |-> !spi_cs_n);  // R1

  AST_RST_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    !cfg_rst_n |-> !spi_cs_n);  // R2

  AST_CS_BEFORE_RST: assert property (@(posedge clk) disable iff (rst)
    $fell(cfg_rst_n) |-> $past(!spi_cs_n));  // R2

  AST_READY_EMPTY: assert property (@(posedge clk) disable iff (rst)
    s_ready |-> (spi_sck && !spi_cs_n && cfg_rst_n));  // R5

  AST_CS_RISE_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> spi_sck);  // R7

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
    !(cfg_ok && cfg_err));  // R12

  AST_OK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfg_ok |=> !cfg_ok);  // R12

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> !cfg_err);  // R12

  AST_BUSY_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n |-> busy);  // R12

  AST_RESULT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_ok || cfg_err) |-> !busy);  // R12

endmodule

bind fpga_cfg_seq fpga_cfg_seq_chk chk_i (.*);

// File: tb/fpga_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module fpga_cfg_seq_tb_top;

  localparam int HALF_DIV    = 2;
  localparam int RST_CYC     = 5;
  localparam int SETUP_CYC   = 20;
  localparam int USER_CYC    = 15;
  localparam int TIMEOUT_CYC = 200;
  localparam int TRAIL_BYTES = 13;

  typedef struct packed {
    logic [7:0] nb;
    logic [7:0] seed;
    logic [1:0] gap;
    logic       poll;
    logic       never;
    logic [7:0] dly;
    logic       exp_ok;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 8'hA5, 2'd0, 1'b1, 1'b0, 8'd3,  1'b1},
    '{8'd5, 8'h3C, 2'd1, 1'b1, 1'b0, 8'd0,  1'b1},
    '{8'd9, 8'hF0, 2'd3, 1'b1, 1'b0, 8'd50, 1'b1},
    '{8'd4, 8'h81, 2'd0, 1'b1, 1'b1, 8'd0,  1'b0},
    '{8'd3, 8'h11, 2'd2, 1'b0, 1'b1, 8'd0,  1'b1},
    '{8'd2, 8'h7E, 2'd0, 1'b0, 1'b0, 8'd5,  1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic done_poll_en = 1'b0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0;
  logic s_last = 1'b0;
  logic cfg_done = 1'b0;
  logic s_ready, cfg_rst_n, spi_cs_n, spi_sck, spi_mosi, busy, cfg_ok, cfg_err, tgt_operating;

  always #10 clk = ~clk;

  fpga_cfg_seq #(
    .HALF_DIV(HALF_DIV), .RST_CYC(RST_CYC), .SETUP_CYC(SETUP_CYC),
    .USER_CYC(USER_CYC), .TIMEOUT_CYC(TIMEOUT_CYC), .TRAIL_BYTES(TRAIL_BYTES),
    .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .start(start), .done_poll_en(done_poll_en),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .cfg_rst_n(cfg_rst_n), .cfg_done(cfg_done), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .busy(busy), .cfg_ok(cfg_ok),
    .cfg_err(cfg_err), .tgt_operating(tgt_operating)
  );

  int n_chk = 0;
  int n_fail = 0;

  int cyc = 0;
  int t_cs_fall, t_cs_rise, t_rst_fall, t_rst_rise, t_first_fall, t_last_rise;
  int t_ok, t_err, t_done_set;
  int cs_rises, rst_falls, rises, ok_cnt, err_cnt;
  bit cs_at_rst;
  logic [7:0] shreg;
  logic [7:0] cap [64];
  logic p_cs = 1'b1, p_rn = 1'b1, p_sck = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (p_cs && !spi_cs_n) t_cs_fall = cyc;
      if (!p_cs && spi_cs_n) begin t_cs_rise = cyc; cs_rises++; end
      if (p_rn && !cfg_rst_n) begin t_rst_fall = cyc; rst_falls++; cs_at_rst = !spi_cs_n; end
      if (!p_rn && cfg_rst_n) t_rst_rise = cyc;
      if (p_sck && !spi_sck && t_first_fall < 0) t_first_fall = cyc;
      if (!p_sck && spi_sck && !spi_cs_n) begin
        shreg = {shreg[6:0], spi_mosi};
        rises++;
        t_last_rise = cyc;
        if (rises % 8 == 0 && rises / 8 <= 64) cap[rises/8 - 1] = shreg;
      end
      if (cfg_ok)  begin ok_cnt++;  t_ok  = cyc; end
      if (cfg_err) begin err_cnt++; t_err = cyc; end
    end
    p_cs = spi_cs_n; p_rn = cfg_rst_n; p_sck = spi_sck;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  task automatic clear_mon();
    t_cs_fall = -1; t_cs_rise = -1; t_rst_fall = -1; t_rst_rise = -1;
    t_first_fall = -1; t_last_rise = -1; t_ok = -1; t_err = -1; t_done_set = -1;
    cs_rises = 0; rst_falls = 0; rises = 0; ok_cnt = 0; err_cnt = 0;
    cs_at_rst = 1'b0; shreg = '0;
  endtask

  task automatic run_vec(input vec_t v, input bit restart);
    logic rdy;
    int lim;
    int bad;
    cfg_done = 1'b0;
    done_poll_en = v.poll;
    repeat (4) tick();
    chk(tgt_operating == 1'b0, "R11", "status unknown with done low", int'(tgt_operating), 0);
    clear_mon();
    start = 1'b1; tick(); start = 1'b0;
    chk(busy == 1'b1, "R12", "busy after start", int'(busy), 1);
    for (int i = 0; i < int'(v.nb); i++) begin
      s_data  = exp_byte(v.seed, i);
      s_last  = (i == int'(v.nb) - 1);
      s_valid = 1'b1;
      lim = 0;
      forever begin
        @(negedge clk); rdy = s_ready;
        tick();
        lim++;
        if (rdy || lim > 4000) break;
      end
      s_valid = 1'b0; s_last = 1'b0;
      if (restart && i == 0) begin
        start = 1'b1; tick(); start = 1'b0;
      end
      repeat (int'(v.gap)) tick();
    end
    lim = 0;
    while (cs_rises == 0 && lim < 5000) begin tick(); lim++; end
    if (!v.never) begin
      repeat (int'(v.dly)) tick();
      cfg_done = 1'b1;
      t_done_set = cyc;
      repeat (4) tick();
      chk(tgt_operating == 1'b1, "R11", "status operating with done high", int'(tgt_operating), 1);
    end
    lim = 0;
    while (ok_cnt + err_cnt == 0 && lim < 3000) begin tick(); lim++; end
    repeat (3) tick();

    chk(rst_falls == 1, "R3", "reset pulse count", rst_falls, 1);
    chk(t_rst_rise - t_rst_fall == RST_CYC, "R3", "reset width", t_rst_rise - t_rst_fall, RST_CYC);
    chk(cs_at_rst && t_cs_fall >= 0 && t_cs_fall < t_rst_fall, "R2", "cs low before reset", t_cs_fall, t_rst_fall - 1);
    chk(cs_rises == 1, "R2", "cs release count", cs_rises, 1);
    chk(t_first_fall - t_rst_rise >= SETUP_CYC, "R4", "setup gap", t_first_fall - t_rst_rise, SETUP_CYC);
    chk(rises == 8 * (int'(v.nb) + TRAIL_BYTES), "R6", "rising edge count", rises, 8 * (int'(v.nb) + TRAIL_BYTES));
    bad = 0;
    for (int i = 0; i < int'(v.nb); i++) if (cap[i] !== exp_byte(v.seed, i)) bad++;
    chk(bad == 0, "R5", "bitstream bytes MSB first mismatches", bad, 0);
    bad = 0;
    for (int i = 0; i < TRAIL_BYTES; i++) if (cap[int'(v.nb) + i] !== 8'h00) bad++;
    chk(bad == 0, "R6", "trailing zero byte mismatches", bad, 0);
    chk(t_cs_rise > t_last_rise, "R7", "cs rise after last edge", t_cs_rise, t_last_rise + 1);
    chk(spi_sck == 1'b1 && spi_cs_n == 1'b1, "R1", "sck idle high after load", int'(spi_sck), 1);
    chk(ok_cnt + err_cnt == 1, "R12", "single result cycle", ok_cnt + err_cnt, 1);
    chk(busy == 1'b0, "R12", "busy low after result", int'(busy), 0);
    if (!v.exp_ok) begin
      chk(err_cnt == 1, "R8", "timeout error pulse", err_cnt, 1);
      chk(t_err - t_cs_rise == TIMEOUT_CYC, "R8", "timeout length", t_err - t_cs_rise, TIMEOUT_CYC);
    end else if (!v.poll) begin
      chk(ok_cnt == 1, "R10", "ok without polling", ok_cnt, 1);
      chk(t_ok - t_cs_rise == USER_CYC, "R10", "user wait from cs rise", t_ok - t_cs_rise, USER_CYC);
    end else begin
      chk(ok_cnt == 1, "R9", "ok after done", ok_cnt, 1);
      chk(t_ok - t_done_set >= USER_CYC, "R9", "user wait after done", t_ok - t_done_set, USER_CYC);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (5) tick();
    rst = 1'b0;
    tick();
    chk(spi_cs_n == 1'b1, "R2", "reset cs_n", int'(spi_cs_n), 1);
    chk(cfg_rst_n == 1'b1, "R12", "reset cfg_rst_n", int'(cfg_rst_n), 1);
    chk(spi_sck == 1'b1, "R1", "reset sck", int'(spi_sck), 1);
    chk(busy == 1'b0 && s_ready == 1'b0, "R12", "reset busy/ready", int'(busy) + int'(s_ready), 0);
    chk(cfg_ok == 1'b0 && cfg_err == 1'b0, "R12", "reset result pulses", int'(cfg_ok) + int'(cfg_err), 0);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

    // R12: start while busy is ignored
    run_vec('{8'd3, 8'h42, 2'd1, 1'b0, 1'b1, 8'd0, 1'b1}, 1'b1);
    repeat (40) tick();
    chk(busy == 1'b0 && spi_cs_n == 1'b1, "R12", "no queued restart", int'(busy), 0);
    chk(rst_falls == 1 && ok_cnt == 1, "R12", "restart ignored pulse count", rst_falls + ok_cnt, 2);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule